// File: doc/BRIEF.md
# Cascaded Power Rail Sequencer

This block drives the enable lines of four supply rails and brings them up and down in a fixed order. Each rail is placed in one of four sequence slots and has its own turn-on and turn-off delay, counted in periods of an external timebase tick. Raising the power request starts from slot 0 and climbs. A slot is released only when every rail of the slot below has been enabled and its 10-bit reading has reached that rail's ON threshold. Lowering the request walks down from slot 3. Moving to the next lower slot waits until every rail in the current one has been disabled and reads under its OFF threshold.

Once the climb completes, the block reports healthy and compares every reading against an undervoltage and an overvoltage limit. A limit violation, a slot that overstays the termination time, or an external force-shutdown drops all enables in one cycle and latches a fault. While the request stays high, a fault-triggered shutdown restarts the climb, up to a programmed number of times. A host-commanded power-off never restarts by itself.

Top module: `rail_sequencer`

## Requirements
- R1: After reset every enable is inactive, healthy and fault are low, and the remaining retry count equals `retry_lim`.
- R2: Bit i of `en_pol` selects the active level of `en[i]`: 1 means active high and 0 means active low.
- R3: A rising `pwr_req` starts turn-on at slot 0. No rail of a higher slot is enabled until every rail of the current slot is enabled and reads at or above its ON threshold. After slot 3 completes, the state becomes running.
- R4: A rail's enable turns on at the (D+1)-th tick counted after its slot begins, where D is its 8-bit on-delay.
- R5: A falling `pwr_req` while running starts turn-off at slot 3 and steps downward. Each rail is released at the (D+1)-th tick after its slot begins, where D is its off-delay. The next lower slot begins only once every rail of the current slot is off and reads below its OFF threshold.
- R6: While running, a reading below its UV limit or above its OV limit causes a fault. On a fault, all enables go inactive, `fault` rises, `fs_out` pulses for one cycle, and `st_fault_ch` marks the offending rails. UV and OV are ignored during turn-on and turn-off. `healthy` is high only while running.
- R7: If a slot has not completed `term_to` ticks after it began, a fault is raised, and `st_fault_ch` marks the rails of that slot that were not yet done.
- R8: `fs_in` high during turn-on, running or turn-off forces a fault in the next cycle with every enable inactive, `fs_out` low and `st_fault_ch` zero.
- R9: In the fault state, with `pwr_req` high, `fs_in` low and a nonzero retry count, the next tick restarts turn-on and decrements the count. At a count of zero the block stays faulted. `pwr_req` low in the fault state returns the block to off, and no restart follows.
- R10: `retry_clr` reloads the retry count from `retry_lim`.
- R11: `st_state` encodes 0 off, 1 turning on, 2 running, 3 turning off and 4 fault. `st_pos` gives the current slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle timebase pulse |
| pwr_req | input | 1 | Power request level |
| fs_in | input | 1 | External force shutdown, active high |
| retry_clr | input | 1 | Reload retry count |
| reading | input | NCH*VW | Rail readings, rail i at bits i*VW |
| on_thr | input | NCH*VW | Per-rail ON thresholds |
| off_thr | input | NCH*VW | Per-rail OFF thresholds |
| uv_thr | input | NCH*VW | Per-rail undervoltage limits |
| ov_thr | input | NCH*VW | Per-rail overvoltage limits |
| pos_cfg | input | NCH*PW | Per-rail sequence slot |
| on_dly | input | NCH*DW | Per-rail turn-on delay in ticks |
| off_dly | input | NCH*DW | Per-rail turn-off delay in ticks |
| en_pol | input | NCH | Enable active level per rail |
| term_to | input | TW | Slot termination time in ticks |
| retry_lim | input | RW | Restart limit |
| en | output | NCH | Rail enables |
| healthy | output | 1 | Turn-on complete and monitoring |
| fault | output | 1 | Fault latched |
| fs_out | output | 1 | One-cycle pulse on a self-detected fault |
| st_state | output | 3 | Sequencer state code |
| st_pos | output | PW | Current slot |
| st_retries | output | RW | Remaining restarts |
| st_fault_ch | output | NCH | Rails blamed for the last fault |

## Verification
On every cycle the assertions check that no rail of a later slot is on during turn-on, that running means every enable is active and fault means every enable is inactive, that force-shutdown takes effect one cycle later without the self-fault pulse, that `fs_out` never lasts two cycles, and that the retry count only falls unless cleared. Only the bench scenarios can show the full enable order across slots, the tick-accurate delays, UV being ignored during a retried climb, the timeout blame mask, running out of retries, and the refusal to restart after a host power-off.

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
  parameter int NCH  = 4,
  parameter int NPOS = 4,
  parameter int VW   = 10,
  parameter int DW   = 8,
  parameter int TW   = 12,
  parameter int RW   = 3,
  localparam int PW  = $clog2(NPOS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pwr_req,
  input  logic              fs_in,
  input  logic              retry_clr,
  input  logic [NCH*VW-1:0] reading,
  input  logic [NCH*VW-1:0] on_thr,
  input  logic [NCH*VW-1:0] off_thr,
  input  logic [NCH*VW-1:0] uv_thr,
  input  logic [NCH*VW-1:0] ov_thr,
  input  logic [NCH*PW-1:0] pos_cfg,
  input  logic [NCH*DW-1:0] on_dly,
  input  logic [NCH*DW-1:0] off_dly,
  input  logic [NCH-1:0]    en_pol,
  input  logic [TW-1:0]     term_to,
  input  logic [RW-1:0]     retry_lim,
  output logic [NCH-1:0]    en,
  output logic              healthy,
  output logic              fault,
  output logic              fs_out,
  output logic [2:0]        st_state,
  output logic [PW-1:0]     st_pos,
  output logic [RW-1:0]     st_retries,
  output logic [NCH-1:0]    st_fault_ch
);

  typedef enum logic [2:0] {S_OFF = 3'd0, S_UP = 3'd1, S_RUN = 3'd2, S_DN = 3'd3, S_FLT = 3'd4} state_t;
  localparam logic [PW-1:0] TOP = PW'(NPOS - 1);

  state_t         state;
  logic [PW-1:0]  pos;
  logic [NCH-1:0] on_r, fch;
  logic [DW-1:0]  cnt [NCH];
  logic [TW-1:0]  tmr;
  logic [RW-1:0]  retries;
  logic           req_q, fs_pulse;

  logic [NCH-1:0] in_pos, later, hi, lo, bad, flt_mask;
  logic           up_done, dn_done, tmo, go_flt, flt_own;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      in_pos[i] = pos_cfg[i*PW +: PW] == pos;
      later[i]  = pos_cfg[i*PW +: PW] > pos;
      hi[i]     = reading[i*VW +: VW] >= on_thr[i*VW +: VW];
      lo[i]     = reading[i*VW +: VW] <  off_thr[i*VW +: VW];
      bad[i]    = (reading[i*VW +: VW] < uv_thr[i*VW +: VW]) ||
                  (reading[i*VW +: VW] > ov_thr[i*VW +: VW]);
    end
  end

  assign up_done = (in_pos & ~(on_r & hi)) == '0;
  assign dn_done = (in_pos & (on_r | ~lo)) == '0;
  assign tmo     = tick && (tmr == term_to - TW'(1));

  always_comb begin
    go_flt   = 1'b0;
    flt_own  = 1'b0;
    flt_mask = '0;
    if (fs_in && (state == S_UP || state == S_RUN || state == S_DN)) begin
      go_flt = 1'b1;
    end else if (state == S_RUN && pwr_req && |bad) begin
      go_flt = 1'b1; flt_own = 1'b1; flt_mask = bad;
    end else if (state == S_UP && pwr_req && !up_done && tmo) begin
      go_flt = 1'b1; flt_own = 1'b1; flt_mask = in_pos & ~(on_r & hi);
    end else if (state == S_DN && !dn_done && tmo) begin
      go_flt = 1'b1; flt_own = 1'b1; flt_mask = in_pos & (on_r | ~lo);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_OFF;
      pos      <= '0;
      on_r     <= '0;
      fch      <= '0;
      tmr      <= '0;
      retries  <= retry_lim;
      req_q    <= 1'b0;
      fs_pulse <= 1'b0;
      for (int i = 0; i < NCH; i++) cnt[i] <= '0;
    end else begin
      req_q    <= pwr_req;
      fs_pulse <= 1'b0;
      if (retry_clr) retries <= retry_lim;
      if (go_flt) begin
        state    <= S_FLT;
        on_r     <= '0;
        fch      <= flt_mask;
        fs_pulse <= flt_own;
      end else begin
        case (state)
          S_OFF: if (pwr_req && !req_q) begin
            state <= S_UP; pos <= '0; tmr <= '0;
            for (int i = 0; i < NCH; i++) cnt[i] <= on_dly[i*DW +: DW];
          end
          S_UP: begin
            if (!pwr_req) begin
              state <= S_DN; pos <= TOP; tmr <= '0;
              for (int i = 0; i < NCH; i++) cnt[i] <= off_dly[i*DW +: DW];
            end else if (up_done) begin
              if (pos == TOP) state <= S_RUN;
              else begin
                pos <= pos + 1'b1; tmr <= '0;
                for (int i = 0; i < NCH; i++) cnt[i] <= on_dly[i*DW +: DW];
              end
            end else if (tick) begin
              tmr <= tmr + 1'b1;
              for (int i = 0; i < NCH; i++)
                if (in_pos[i] && !on_r[i]) begin
                  if (cnt[i] == '0) on_r[i] <= 1'b1;
                  else cnt[i] <= cnt[i] - 1'b1;
                end
            end
          end
          S_RUN: if (!pwr_req) begin
            state <= S_DN; pos <= TOP; tmr <= '0;
            for (int i = 0; i < NCH; i++) cnt[i] <= off_dly[i*DW +: DW];
          end
          S_DN: begin
            if (dn_done) begin
              if (pos == '0) state <= S_OFF;
              else begin
                pos <= pos - 1'b1; tmr <= '0;
                for (int i = 0; i < NCH; i++) cnt[i] <= off_dly[i*DW +: DW];
              end
            end else if (tick) begin
              tmr <= tmr + 1'b1;
              for (int i = 0; i < NCH; i++)
                if (in_pos[i] && on_r[i]) begin
                  if (cnt[i] == '0) on_r[i] <= 1'b0;
                  else cnt[i] <= cnt[i] - 1'b1;
                end
            end
          end
          S_FLT: begin
            if (!pwr_req) state <= S_OFF;
            else if (tick && !fs_in && retries != '0) begin
              retries <= retries - 1'b1;
              state <= S_UP; pos <= '0; tmr <= '0;
              for (int i = 0; i < NCH; i++) cnt[i] <= on_dly[i*DW +: DW];
            end
          end
          default: state <= S_OFF;
        endcase
      end
    end
  end

  assign en          = ~(on_r ^ en_pol);
  assign healthy     = state == S_RUN;
  assign fault       = state == S_FLT;
  assign fs_out      = fs_pulse;
  assign st_state    = state;
  assign st_pos      = pos;
  assign st_retries  = retries;
  assign st_fault_ch = fch;

  a_r3_no_early_rail: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_UP) |-> ((on_r & later) == '0));
  a_r6_run_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    healthy |-> (en == en_pol));
  a_r6_fault_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (en == ~en_pol));
  a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    fs_out |=> !fs_out);
  a_r8_force_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_in && (state == S_UP || state == S_RUN || state == S_DN)) |=> (fault && !fs_out && st_fault_ch == '0));
  a_r10_retry_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !retry_clr |=> (st_retries <= $past(st_retries)));

endmodule

// File: tb/test_rail_sequencer.sv
module test_rail_sequencer;
  localparam int NCH = 4, VW = 10, DW = 8, TW = 12, RW = 3, PW = 2;
  localparam logic [3:0] POL = 4'b1010;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pwr_req = 1'b0, fs_in = 1'b0, retry_clr = 1'b0;
  logic [1:0] tcnt = 2'd0;
  logic [3:0] rail_on = 4'd0, ovr = 4'd0, prev = 4'd0;
  logic [NCH*VW-1:0] reading;
  logic [NCH-1:0] en, st_fault_ch;
  logic healthy, fault, fs_out;
  logic [2:0] st_state;
  logic [PW-1:0] st_pos;
  logic [RW-1:0] st_retries;
  logic [3:0] q[$];
  int checks = 0, errors = 0, n;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) begin tcnt <= tcnt + 1'b1; tick <= (tcnt == 2'd3); end
  always @(posedge clk) rail_on <= ~(en ^ POL);
  always_comb
    for (int i = 0; i < NCH; i++)
      reading[i*VW +: VW] = ovr[i] ? 10'd300 : (rail_on[i] ? 10'd700 : 10'd50);

  rail_sequencer i_rail_sequencer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_req(pwr_req), .fs_in(fs_in), .retry_clr(retry_clr),
    .reading(reading), .on_thr({4{10'd600}}), .off_thr({4{10'd100}}),
    .uv_thr({4{10'd500}}), .ov_thr({4{10'd900}}),
    .pos_cfg({2'd1, 2'd1, 2'd0, 2'd2}),
    .on_dly({8'd5, 8'd2, 8'd1, 8'd3}), .off_dly({8'd0, 8'd4, 8'd2, 8'd1}),
    .en_pol(POL), .term_to(12'd20), .retry_lim(3'd2),
    .en(en), .healthy(healthy), .fault(fault), .fs_out(fs_out), .st_state(st_state),
    .st_pos(st_pos), .st_retries(st_retries), .st_fault_ch(st_fault_ch));

  function automatic logic [3:0] ph(input logic [3:0] l);
    return ~(l ^ POL);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] l);
    q.push_back(ph(l));
  endtask

  task automatic push_up();
    push(4'b0010); push(4'b0110); push(4'b1110); push(4'b1111);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // scoreboard monitor: every enable change must match the next expected vector
  always @(negedge clk) begin
    if (rst_n && en !== prev) begin
      if (q.size() == 0) chk(0, "R3 R5 R6 R8 unexpected enable change", en, prev);
      else begin
        logic [3:0] e;
        e = q.pop_front();
        chk(en == e, "R3 R5 R6 R8 enable order", en, e);
      end
    end
    prev = en;
  end

  initial begin
    repeat (60000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(en == ph(4'b0000), "R1 reset enables", en, ph(4'b0000));
    chk(en == 4'b0101, "R2 idle polarity", en, 4'b0101);
    chk(!healthy && !fault, "R1 flags", {healthy, fault}, 0);
    chk(st_state == 3'd0, "R11 off code", st_state, 0);
    chk(st_retries == 3'd2, "R1 retry load", st_retries, 2);

    push_up();
    while (tick) @(negedge clk);
    pwr_req = 1'b1;
    n = 0;
    do begin @(negedge clk); n += tick; end while (!en[1]);
    chk(n == 2, "R4 on delay ticks", n, 2);
    while (!healthy) @(negedge clk);
    chk(q.size() == 0, "R3 climb complete", q.size(), 0);
    chk(st_state == 3'd2 && st_pos == 2'd3, "R11 run status", {st_state, st_pos}, {3'd2, 2'd3});

    push(4'b0000);
    push(4'b0010); push(4'b0110); push(4'b1110); push(4'b0000);
    push(4'b0010); push(4'b0110); push(4'b1110); push(4'b0000);
    ovr = 4'b0100;
    @(negedge clk);
    chk(fault && st_state == 3'd4, "R6 UV fault", st_state, 4);
    chk(fs_out, "R6 fs_out pulse", fs_out, 1);
    chk(st_fault_ch == 4'b0100, "R6 fault mask", st_fault_ch, 4'b0100);
    @(negedge clk);
    chk(!fs_out, "R6 pulse width", fs_out, 0);
    while (st_state != 3'd1) @(negedge clk);
    chk(st_retries == 3'd1, "R9 retry decrement", st_retries, 1);
    while (!(fault && st_retries == 3'd0)) @(negedge clk);
    chk(st_fault_ch == 4'b0100, "R7 timeout mask", st_fault_ch, 4'b0100);
    repeat (40) @(negedge clk);
    chk(fault && st_state == 3'd4, "R9 retries exhausted", st_state, 4);
    chk(q.size() == 0, "R6 R7 R9 retry sequence", q.size(), 0);

    ovr = 4'b0000;
    pwr_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(st_state == 3'd0, "R9 host off", st_state, 0);
    repeat (20) @(negedge clk);
    chk(st_state == 3'd0 && en == ph(4'b0000), "R9 no restart", en, ph(4'b0000));
    retry_clr = 1'b1;
    @(negedge clk);
    retry_clr = 1'b0;
    chk(st_retries == 3'd2, "R10 retry reload", st_retries, 2);

    push_up();
    pwr_req = 1'b1;
    while (!healthy) @(negedge clk);
    push(4'b0000);
    fs_in = 1'b1;
    @(negedge clk);
    chk(fault && !fs_out, "R8 forced fault", {fault, fs_out}, 2);
    chk(st_fault_ch == 4'b0000, "R8 empty mask", st_fault_ch, 0);
    repeat (10) @(negedge clk);
    chk(st_state == 3'd4 && st_retries == 3'd2, "R9 hold while forced", st_retries, 2);
    push_up();
    fs_in = 1'b0;
    while (!healthy) @(negedge clk);
    chk(st_retries == 3'd1, "R9 restart after force", st_retries, 1);

    push(4'b1110); push(4'b0110); push(4'b0010); push(4'b0000);
    pwr_req = 1'b0;
    @(negedge clk);
    chk(st_state == 3'd3, "R11 down code", st_state, 3);
    while (en[3]) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n += tick; end while (!en[2]);
    chk(n == 4, "R5 off delay spacing", n, 4);
    while (st_state != 3'd0) @(negedge clk);
    chk(q.size() == 0, "R5 descent complete", q.size(), 0);
    chk(en == ph(4'b0000), "R5 all released", en, ph(4'b0000));
    finish_run();
  end
endmodule